// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It tracks the sixteen-state test access port sequence from the mode-select input, holds a three-bit instruction, decodes it into select and mode lines, and owns two small data registers: a one-bit bypass stage and a 32-bit identification register. A boundary-scan chain built outside the block uses the capture, shift and update strobes, and it returns its serial output through `bs_so`. The block steers that output, or one of its own registers, to the serial output pin.

Inputs are sampled on the rising test clock edge. The serial output and its enable change only on the falling edge. An instruction shifted into the shift stage reaches the hold stage, and so changes the decoded selects, only on the falling edge while the controller sits in Update-IR. An active-low asynchronous reset, or five rising edges with mode-select high, returns the controller to Test-Logic-Reset, and the identification instruction is selected there.

Top module: `tap_port_ctrl`

## Requirements
- R1: With `trst_n` low the controller is in Test-Logic-Reset at once, without a clock edge: `idcode_sel` is 1 and `tdo_oe` and `tdo` are 0.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the identification instruction (001) is then selected.
- R3: In Capture-IR the instruction shift stage loads 001, so the first three bits on `tdo` in Shift-IR are 1, 0, 0.
- R4: The instruction is shifted in least significant bit first (the MSB ends nearest `tdi`). The decoded selects change only on the falling edge while in Update-IR, and not at the rising edge that enters Update-IR.
- R5: Decode: 000 selects the boundary chain with external-test mode, 001 the identification register, 100 the boundary chain with no mode, 101 the bypass register with high-impedance mode, 110 the bypass register with clamp mode, 111 the bypass register.
- R6: The unused codes 010 and 011 act exactly as 111.
- R7: With 001 selected, Capture-DR loads the identification value `ID_VALUE` (bit 0 is 1), and a 32-bit DR scan returns it least significant bit first.
- R8: With the bypass register selected, Capture-DR loads 0, and `tdo` repeats `tdi` one shift later.
- R9: `tdo_oe` is 1 exactly in Shift-IR and Shift-DR, and `tdo` and `tdo_oe` change only on falling `tck` edges.
- R10: `bs_capture`, `bs_shift` and `bs_update` pulse in Capture-DR, Shift-DR and Update-DR only while a boundary-chain instruction (000 or 100) is held. In Shift-DR under these instructions, `tdo` carries `bs_so`.
- R11: `core_reset_req` is 1 while 000, 101 or 110 is held, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bs_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| idcode_sel | output | 1 | Identification register is selected |
| bypass_sel | output | 1 | Bypass register is selected |
| extest_mode | output | 1 | External-test instruction held |
| highz_mode | output | 1 | Output float instruction held |
| clamp_mode | output | 1 | Clamp instruction held |
| core_reset_req | output | 1 | Functional logic must be held in reset |
| bs_capture | output | 1 | Capture strobe for the boundary chain |
| bs_shift | output | 1 | Shift strobe for the boundary chain |
| bs_update | output | 1 | Update strobe for the boundary chain |

## Verification
The hardest case to reach from the ports is the half cycle after the rising edge that enters Update-IR. The old instruction must still be decoded there, and the new one must appear only after the next falling edge. The bench stops its serial driver at that edge and samples the selects once on each side of the falling edge. A second hard case is an asynchronous reset in the middle of a data shift while `tdo_oe` is high. The bench drives the controller into Shift-DR under the bypass instruction and drops `trst_n` between clock edges. A third is the five-ones return to reset started from deep inside the data branch, where the walk must pass through both select states.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b101;
  localparam logic [IR_W-1:0] OP_CLAMP   = 3'b110;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_hold
);
  // shift stage: rising edge, LSB leaves first, TDI enters at the MSB
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                ir_shift <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_shift <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
  end

  // hold stage: falling edge, only in Update-IR or reset
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_hold <= OP_IDCODE;
    else if (state == ST_TLR)    ir_hold <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_hold <= ir_shift;
  end
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr #(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B6E_301D
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture,
  input  logic shift,
  input  logic sel_id,
  input  logic sel_byp,
  output logic byp_bit,
  output logic id_bit
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                byp_bit <= 1'b0;
    else if (capture && sel_byp) byp_bit <= 1'b0;
    else if (shift && sel_byp)   byp_bit <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                id_q <= ID_VALUE;
    else if (capture && sel_id)  id_q <= ID_VALUE;
    else if (shift && sel_id)    id_q <= {tdi, id_q[ID_W-1:1]};
  end

  assign id_bit = id_q[0];
endmodule

// File: rtl/tap_port_ctrl.sv
`timescale 1ns/1ps
module tap_port_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B6E_301D
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bs_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_sel,
  output logic idcode_sel,
  output logic bypass_sel,
  output logic extest_mode,
  output logic highz_mode,
  output logic clamp_mode,
  output logic core_reset_req,
  output logic bs_capture,
  output logic bs_shift,
  output logic bs_update
);
  tap_state_e      cur_state;
  logic [IR_W-1:0] ir_shift_q;
  logic [IR_W-1:0] ir_hold_q;
  logic            dr_capture, dr_shift, dr_update;
  logic            byp_bit, id_bit, tdo_nxt, oe_nxt;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(cur_state));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(cur_state),
    .ir_shift(ir_shift_q), .ir_hold(ir_hold_q)
  );

  // instruction decode; codes without a meaning fall to bypass
  always_comb begin
    bsr_sel     = 1'b0;
    idcode_sel  = 1'b0;
    bypass_sel  = 1'b0;
    extest_mode = 1'b0;
    highz_mode  = 1'b0;
    clamp_mode  = 1'b0;
    case (ir_hold_q)
      OP_EXTEST: begin bsr_sel = 1'b1; extest_mode = 1'b1; end
      OP_SAMPLE: bsr_sel = 1'b1;
      OP_IDCODE: idcode_sel = 1'b1;
      OP_HIGHZ:  begin bypass_sel = 1'b1; highz_mode = 1'b1; end
      OP_CLAMP:  begin bypass_sel = 1'b1; clamp_mode = 1'b1; end
      default:   bypass_sel = 1'b1;
    endcase
  end

  assign core_reset_req = extest_mode | highz_mode | clamp_mode;

  assign dr_capture = (cur_state == ST_CAP_DR);
  assign dr_shift   = (cur_state == ST_SH_DR);
  assign dr_update  = (cur_state == ST_UPD_DR);
  assign bs_capture = dr_capture & bsr_sel;
  assign bs_shift   = dr_shift & bsr_sel;
  assign bs_update  = dr_update & bsr_sel;

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture(dr_capture), .shift(dr_shift),
    .sel_id(idcode_sel), .sel_byp(bypass_sel),
    .byp_bit(byp_bit), .id_bit(id_bit)
  );

  // output mux, retimed to the falling edge
  always_comb begin
    tdo_nxt = 1'b0;
    oe_nxt  = 1'b0;
    if (cur_state == ST_SH_IR) begin
      tdo_nxt = ir_shift_q[0];
      oe_nxt  = 1'b1;
    end else if (cur_state == ST_SH_DR) begin
      oe_nxt = 1'b1;
      if (bsr_sel)         tdo_nxt = bs_so;
      else if (idcode_sel) tdo_nxt = id_bit;
      else                 tdo_nxt = byp_bit;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_oe <= oe_nxt;
    end
  end
endmodule

// File: rtl/tap_port_ctrl_chk.sv
`timescale 1ns/1ps
module tap_port_ctrl_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdo_oe,
  input logic            idcode_sel,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_shift,
  input logic [IR_W-1:0] ir_hold
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             ones_cnt <= 3'd0;
    else if (!tms)           ones_cnt <= 3'd0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_RESET_PICKS_ID: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> idcode_sel); // R1

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_TLR)); // R2

  AST_IR_CAPTURE_BITS: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_SH_IR && $past(state) == ST_CAP_IR) |-> (ir_shift == IR_CAPTURE)); // R3

  AST_HOLD_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_hold != $past(ir_hold)) |-> (state == ST_UPD_IR || state == ST_TLR)); // R4

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR)); // R9
endmodule

bind tap_port_ctrl tap_port_ctrl_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe),
  .idcode_sel(idcode_sel), .state(cur_state),
  .ir_shift(ir_shift_q), .ir_hold(ir_hold_q)
);

// File: tb/test_tap_port_ctrl.sv
`timescale 1ns/1ps
module test_tap_port_ctrl;
  localparam logic [31:0] BENCH_ID = 32'h2B6E_301D;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bs_so = 1'b0;
  logic tdo, tdo_oe, bsr_sel, idcode_sel, bypass_sel, extest_mode, highz_mode;
  logic clamp_mode, core_reset_req, bs_capture, bs_shift, bs_update;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic s_tdo;
  int c_cap, c_sh, c_upd, c_oe;

  always #4 tck = ~tck;

  tap_port_ctrl #(.ID_W(32), .ID_VALUE(BENCH_ID)) i_tap_port_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bs_so(bs_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel), .idcode_sel(idcode_sel),
    .bypass_sel(bypass_sel), .extest_mode(extest_mode), .highz_mode(highz_mode),
    .clamp_mode(clamp_mode), .core_reset_req(core_reset_req),
    .bs_capture(bs_capture), .bs_shift(bs_shift), .bs_update(bs_update)
  );

  // {code, bsr, id, byp, extest, highz, clamp, core_reset}
  localparam logic [9:0] VEC [8] = '{
    {3'b000, 7'b1001001}, {3'b001, 7'b0100000}, {3'b010, 7'b0010000},
    {3'b011, 7'b0010000}, {3'b100, 7'b1000000}, {3'b101, 7'b0010101},
    {3'b110, 7'b0010011}, {3'b111, 7'b0010000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] sels();
    return {bsr_sel, idcode_sel, bypass_sel, extest_mode, highz_mode, clamp_mode, core_reset_req};
  endfunction

  // drive after the falling edge, sample before the next rising edge
  task automatic tick(input logic t, input logic d);
    @(negedge tck); #1;
    tms = t; tdi = d;
    #2;
    s_tdo = tdo;
    c_cap += int'(bs_capture);
    c_sh  += int'(bs_shift);
    c_upd += int'(bs_update);
    c_oe  += int'(tdo_oe);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i]);
      cap[i] = s_tdo;
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0; c_cap = 0; c_sh = 0; c_upd = 0; c_oe = 0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = s_tdo;
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  cap;
    logic [31:0] dout, exp;
    bit          is_bsr;
    int          n;
    // R1: reset state
    #20;
    check("R1 idcode_sel in reset", 32'(idcode_sel), 1);
    check("R1 tdo_oe in reset", 32'(tdo_oe), 0);
    check("R1 tdo in reset", 32'(tdo), 0);
    trst_n = 1'b1;
    tick(1'b0, 1'b0);

    // table walk: R3 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      code = VEC[v][9:7];
      load_ir(code, cap);
      check("R3 capture pattern", 32'(cap), 32'b001);
      check((code == 3'b010 || code == 3'b011) ? "R6 unused decode" : "R5 decode",
            32'(sels()), 32'(VEC[v][6:0]));
      check("R11 core reset", 32'(core_reset_req), 32'(VEC[v][0]));
      is_bsr = (code == 3'b000 || code == 3'b100);
      bs_so = (code == 3'b000);
      n = (code == 3'b001) ? 32 : 8;
      scan_dr(n, 32'hA5, dout);
      if (code == 3'b001)  exp = BENCH_ID;
      else if (is_bsr)     exp = bs_so ? 32'hFF : 32'h0;
      else                 exp = 32'h4A;
      check(code == 3'b001 ? "R7 idcode scan" : (is_bsr ? "R10 bs_so route" : "R8 bypass scan"),
            dout, exp);
      check("R10 capture strobes", 32'(c_cap), is_bsr ? 1 : 0);
      check("R10 shift strobes", 32'(c_sh), is_bsr ? 32'(n) : 0);
      check("R10 update strobes", 32'(c_upd), is_bsr ? 1 : 0);
      check("R9 oe only in shift", 32'(c_oe), 32'(n));
    end
    check("R9 oe off in idle", 32'(tdo_oe), 0);

    // R4: selects change on the falling edge inside Update-IR, not before
    load_ir(3'b001, cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    check("R4 no change in exit", 32'(idcode_sel), 1);
    tick(1'b1, 1'b0);
    @(posedge tck); #1;
    check("R4 old code at update entry", 32'(idcode_sel), 1);
    check("R4 bypass not yet", 32'(bypass_sel), 0);
    @(negedge tck); #1;
    tms = 1'b0;
    check("R4 new code after falling edge", 32'(bypass_sel), 1);
    check("R4 id dropped", 32'(idcode_sel), 0);

    // R4: bit order; 100 shifted LSB first selects sample
    load_ir(3'b100, cap);
    check("R4 bit order sample", 32'(sels()), 32'b1000000);

    // R2: five ones from Shift-DR
    load_ir(3'b111, cap);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    check("R2 id after five ones", 32'(idcode_sel), 1);
    tick(1'b0, 1'b0);
    scan_dr(32, 32'h0, dout);
    check("R2 id scan after five ones", dout, BENCH_ID);

    // R1: asynchronous reset in the middle of a shift
    load_ir(3'b111, cap);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R1 oe high before reset", 32'(tdo_oe), 1);
    trst_n = 1'b0;
    #0.5;
    check("R1 async oe", 32'(tdo_oe), 0);
    check("R1 async id select", 32'(idcode_sel), 1);
    tick(1'b0, 1'b0);
    trst_n = 1'b1;
    tick(1'b0, 1'b0);

    // R8: second bypass pattern through unused code 011
    load_ir(3'b011, cap);
    scan_dr(8, 32'h3C, dout);
    check("R8 bypass pattern 3C", dout, 32'h78);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule